// File: doc/BRIEF.md
# Memory Data-Width Matching Sequencer

This block connects a wide host data path to a single external memory bank that may be narrower than the host. The bank width (8, 16, 32 or 64 bits) is given with each request as a two-bit code, together with a flag that turns width matching on or off for that bank. With matching on and a narrow bank, one host transfer becomes a run of memory beats. Write data is handed to the memory one group of byte lanes at a time. Read data is gathered lane by lane into a full host word, and the host receives it with one acknowledge after the last beat.

Bits are labelled big-endian: bit 0 is the most significant bit. In a SystemVerilog vector this is the top bit. Host byte lane i is `data[HOST_W-1-8*i -: 8]`, and its byte enable is `be[NB-1-i]`, where NB = HOST_W/8. A narrow bank occupies the memory bus starting at bit 0, which is the top of the vector. Memory lane j uses the same formulas. A timing engine outside this block paces each beat: it pulses `beat_done` once the current memory cycle is finished.

Top module: `wm_seq`

## Requirements
- R1: With matching on and a legal bank width, one request produces HOST_W/bank-width memory beats. This is 1 beat when the bank is as wide as the host. Bank codes: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits.
- R2: With matching off, a legal request produces exactly one memory beat, whatever the bank width.
- R3: On write beat b of a bank that is wb bytes wide, memory lane j (for j < wb) carries host lane b*wb+j. Beats run in ascending lane order. Memory lanes j >= wb drive zero.
- R4: On each beat, memory byte enable lane j equals the host byte enable of host lane b*wb+j for j < wb, and is 0 for j >= wb. While no beat is active, all memory byte enables are 0.
- R5: On reads, host lane b*wb+j receives memory lane j of beat b. Memory lanes at or above the bank width are ignored. Host lanes that no beat fills read as zero.
- R6: A transfer gives exactly one single-cycle acknowledge (rd_ack for reads, wr_ack for writes) in the cycle after the final beat completes, and no acknowledge earlier. rd_data holds the assembled word from that cycle until the next read acknowledge.
- R7: The memory address of the first beat is the request address. It advances by the bank width in bytes (1, 2, 4 or 8) each time a beat completes.
- R8: A request whose bank width exceeds the host width raises err for exactly one cycle, the cycle after acceptance, and starts no beat.
- R9: After reset, mem_valid, mem_be, rd_ack, wr_ack and err are all zero.
- R10: While a beat is waiting for beat_done, mem_valid, mem_addr, mem_wdata and mem_be stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| req_valid | input | 1 | Request strobe; taken when no transfer is in progress |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the first memory beat |
| req_wdata | input | HOST_W | Host write word |
| req_be | input | HOST_W/8 | Host byte enables (MSB = lane 0) |
| bank_code | input | 2 | Bank width code: 0=8, 1=16, 2=32, 3=64 bits |
| bank_match | input | 1 | Width matching enable for this bank |
| mem_valid | output | 1 | A memory beat is active |
| mem_write | output | 1 | Active beat is a write |
| mem_addr | output | ADDR_W | Address of the active beat |
| mem_wdata | output | HOST_W | Memory write data, bank aligned to bit 0 |
| mem_be | output | HOST_W/8 | Memory byte enables for the active beat |
| mem_rdata | input | HOST_W | Memory read data, bank aligned to bit 0 |
| beat_done | input | 1 | Current beat has completed |
| rd_data | output | HOST_W | Assembled read word |
| rd_ack | output | 1 | Read data valid, one cycle |
| wr_ack | output | 1 | Write finished, one cycle |
| err | output | 1 | Request rejected: bank wider than host |

## Verification
The bench builds the block with a 32-bit host and a 16-bit address. At that size every bank code, both matching settings and both directions can be swept exhaustively. The 64-bit code is illegal at this host width, so the error path is exercised by the same sweep. With a four-lane host, every slicing and assembly pattern (four, two and one beats) shows up in a few cycles. Beat completion is delayed on alternate beats, so the hold behaviour is checked during real waits.

// File: rtl/wm_pkg.sv
package wm_pkg;

    typedef enum logic [1:0] {
        BW_8  = 2'd0,
        BW_16 = 2'd1,
        BW_32 = 2'd2,
        BW_64 = 2'd3
    } bank_width_e;

    function automatic int lane_bytes(input logic [1:0] code);
        return 1 << code;
    endfunction

endpackage

// File: rtl/wm_wr_slice.sv
module wm_wr_slice #(
    parameter int HOST_W = 64,
    parameter int BEAT_W = 3
) (
    input  logic [HOST_W-1:0]   wdata,
    input  logic [HOST_W/8-1:0] be,
    input  logic [BEAT_W-1:0]   beat,
    input  logic [1:0]          code,
    input  logic                active,
    output logic [HOST_W-1:0]   mdata,
    output logic [HOST_W/8-1:0] mbe
);
    localparam int NB = HOST_W / 8;

    for (genvar j = 0; j < NB; j++) begin : g_lane
        logic [7:0] lane_d;
        logic       lane_be;
        always_comb begin
            int h;
            int hs;
            logic sel;
            h       = (int'(beat) << code) + j;
            sel     = active && (j < wm_pkg::lane_bytes(code)) && (h < NB);
            hs      = sel ? h : 0;
            lane_d  = sel ? wdata[HOST_W-1-8*hs -: 8] : 8'h00;
            lane_be = sel ? be[NB-1-hs] : 1'b0;
        end
        assign mdata[HOST_W-1-8*j -: 8] = lane_d;
        assign mbe[NB-1-j]              = lane_be;
    end

endmodule

// File: rtl/wm_rd_pack.sv
module wm_rd_pack #(
    parameter int HOST_W = 64,
    parameter int BEAT_W = 3
) (
    input  logic [HOST_W-1:0] cur,
    input  logic [HOST_W-1:0] mrdata,
    input  logic [BEAT_W-1:0] beat,
    input  logic [1:0]        code,
    input  logic              capture,
    output logic [HOST_W-1:0] nxt
);
    localparam int NB = HOST_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] lane_d;
        always_comb begin
            int grp;
            int src;
            grp    = i >> code;
            src    = i & (wm_pkg::lane_bytes(code) - 1);
            lane_d = cur[HOST_W-1-8*i -: 8];
            if (capture && grp == int'(beat)) begin
                lane_d = mrdata[HOST_W-1-8*src -: 8];
            end
        end
        assign nxt[HOST_W-1-8*i -: 8] = lane_d;
    end

endmodule

// File: rtl/wm_seq.sv
module wm_seq #(
    parameter int HOST_W = 64,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [HOST_W-1:0]   req_wdata,
    input  logic [HOST_W/8-1:0] req_be,
    input  logic [1:0]          bank_code,
    input  logic                bank_match,
    output logic                mem_valid,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [HOST_W-1:0]   mem_wdata,
    output logic [HOST_W/8-1:0] mem_be,
    input  logic [HOST_W-1:0]   mem_rdata,
    input  logic                beat_done,
    output logic [HOST_W-1:0]   rd_data,
    output logic                rd_ack,
    output logic                wr_ack,
    output logic                err
);
    localparam int NB     = HOST_W / 8;
    localparam int NB_LOG = $clog2(NB);
    localparam int BEAT_W = (NB_LOG > 0) ? NB_LOG : 1;

    typedef struct packed {
        logic              busy;
        logic              write;
        logic [1:0]        code;
        logic [BEAT_W-1:0] last;
        logic [BEAT_W-1:0] beat;
        logic [ADDR_W-1:0] addr;
        logic [HOST_W-1:0] wdata;
        logic [NB-1:0]     be;
        logic [HOST_W-1:0] acc;
        logic [HOST_W-1:0] rdata;
        logic              rd_ack;
        logic              wr_ack;
        logic              err;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [HOST_W-1:0] slice_data;
    logic [NB-1:0]     slice_be;
    logic [HOST_W-1:0] acc_nxt;
    logic              capture;
    logic              req_legal;
    logic [1:0]        cur_code;

    assign capture   = st_q.busy && !st_q.write && beat_done;
    assign req_legal = wm_pkg::lane_bytes(bank_code) <= NB;
    assign cur_code  = st_q.code;

    wm_wr_slice #(.HOST_W(HOST_W), .BEAT_W(BEAT_W)) i_slice (
        .wdata  (st_q.wdata),
        .be     (st_q.be),
        .beat   (st_q.beat),
        .code   (st_q.code),
        .active (st_q.busy),
        .mdata  (slice_data),
        .mbe    (slice_be)
    );

    wm_rd_pack #(.HOST_W(HOST_W), .BEAT_W(BEAT_W)) i_pack (
        .cur     (st_q.acc),
        .mrdata  (mem_rdata),
        .beat    (st_q.beat),
        .code    (st_q.code),
        .capture (capture),
        .nxt     (acc_nxt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rd_ack = 1'b0;
        st_d.wr_ack = 1'b0;
        st_d.err    = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                if (!req_legal) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.busy  = 1'b1;
                    st_d.write = req_write;
                    st_d.code  = bank_code;
                    st_d.last  = bank_match ? BEAT_W'((NB >> bank_code) - 1) : '0;
                    st_d.beat  = '0;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.be    = req_be;
                    st_d.acc   = '0;
                end
            end
        end else if (beat_done) begin
            st_d.acc  = acc_nxt;
            st_d.addr = st_q.addr + ADDR_W'(wm_pkg::lane_bytes(st_q.code));
            if (st_q.beat == st_q.last) begin
                st_d.busy = 1'b0;
                if (st_q.write) begin
                    st_d.wr_ack = 1'b1;
                end else begin
                    st_d.rd_ack = 1'b1;
                    st_d.rdata  = acc_nxt;
                end
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_valid = st_q.busy;
    assign mem_write = st_q.busy && st_q.write;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.write ? slice_data : '0;
    assign mem_be    = slice_be;
    assign rd_data   = st_q.rdata;
    assign rd_ack    = st_q.rd_ack;
    assign wr_ack    = st_q.wr_ack;
    assign err       = st_q.err;

endmodule

// File: rtl/wm_seq_chk.sv
module wm_seq_chk #(
    parameter int HOST_W = 64,
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mem_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [HOST_W-1:0]   mem_wdata,
    input logic [HOST_W/8-1:0] mem_be,
    input logic                beat_done,
    input logic                rd_ack,
    input logic                wr_ack,
    input logic                err,
    input logic [1:0]          cur_code
);
    a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_ack, wr_ack, err}));

    a_r6_ack_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack || wr_ack) |-> ($past(mem_valid && beat_done) && !mem_valid));

    a_r8_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_valid && $past(!mem_valid)));

    a_r4_idle_be: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> (mem_be == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !beat_done) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be)));

    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && beat_done) |=>
            (!mem_valid || mem_addr == $past(mem_addr) + ADDR_W'(1 << $past(cur_code))));

endmodule

bind wm_seq wm_seq_chk #(.HOST_W(HOST_W), .ADDR_W(ADDR_W)) i_wm_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .beat_done (beat_done),
    .rd_ack    (rd_ack),
    .wr_ack    (wr_ack),
    .err       (err),
    .cur_code  (cur_code)
);

// File: tb/test_wm_seq.sv
module test_wm_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 32;
    localparam int AW = 16;
    localparam int NB = HW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [HW-1:0] req_wdata = '0;
    logic [NB-1:0] req_be = '0;
    logic [1:0]    bank_code = '0;
    logic          bank_match = 1'b0;
    logic          mem_valid, mem_write;
    logic [AW-1:0] mem_addr;
    logic [HW-1:0] mem_wdata;
    logic [NB-1:0] mem_be;
    logic [HW-1:0] mem_rdata = '0;
    logic          beat_done = 1'b0;
    logic [HW-1:0] rd_data;
    logic          rd_ack, wr_ack, err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wm_seq #(.HOST_W(HW), .ADDR_W(AW)) i_wm_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .bank_code(bank_code), .bank_match(bank_match), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rdata(mem_rdata), .beat_done(beat_done),
        .rd_data(rd_data), .rd_ack(rd_ack), .wr_ack(wr_ack), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a, input int j);
        return 8'((a + j) * 37 + 11);
    endfunction

    task automatic run(input bit wr, input int code, input bit m,
                       input logic [AW-1:0] a, input logic [HW-1:0] wd, input logic [NB-1:0] be);
        int wb;
        int nb;
        logic [HW-1:0] exp_rd;
        logic [HW-1:0] prev_rd;
        wb = 1 << code;
        nb = (wb > NB) ? 0 : (m ? NB / wb : 1);
        prev_rd = rd_data;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        bank_code = 2'(code); bank_match = m;
        @(negedge clk);
        req_valid = 1'b0;
        if (nb == 0) begin
            chk(err == 1'b1, "R8 err raised", 64'(err), 64'd1);
            chk(mem_valid == 1'b0, "R8 no beat", 64'(mem_valid), 64'd0);
            @(negedge clk);
            chk(err == 1'b0, "R8 err one cycle", 64'(err), 64'd0);
            chk(mem_valid == 1'b0, "R8 still no beat", 64'(mem_valid), 64'd0);
            chk(rd_data == prev_rd, "R6 rd_data held", 64'(rd_data), 64'(prev_rd));
            return;
        end
        exp_rd = '0;
        for (int b = 0; b < nb; b++) begin
            logic [HW-1:0] exp_d;
            logic [NB-1:0] exp_be;
            logic [HW-1:0] rdv;
            logic [AW-1:0] exp_a;
            exp_d = '0; exp_be = '0; rdv = {NB{8'hEE}};
            exp_a = a + AW'(b * wb);
            for (int j = 0; j < wb; j++) begin
                int h;
                h = b * wb + j;
                exp_d[HW-1-8*j -: 8] = wd[HW-1-8*h -: 8];
                exp_be[NB-1-j] = be[NB-1-h];
                rdv[HW-1-8*j -: 8] = pat(int'(exp_a), j);
                exp_rd[HW-1-8*h -: 8] = pat(int'(exp_a), j);
            end
            chk(mem_valid == 1'b1, m ? "R1 beat active" : "R2 beat active", 64'(mem_valid), 64'd1);
            chk(!rd_ack && !wr_ack, "R6 no early ack", 64'({rd_ack, wr_ack}), 64'd0);
            chk(mem_addr == exp_a, "R7 beat address", 64'(mem_addr), 64'(exp_a));
            chk(mem_write == wr, "R3 write flag", 64'(mem_write), 64'(wr));
            chk(mem_be == exp_be, "R4 beat byte enables", 64'(mem_be), 64'(exp_be));
            if (wr) chk(mem_wdata == exp_d, "R3 write slice", 64'(mem_wdata), 64'(exp_d));
            mem_rdata = rdv;
            if (b % 2 == 1) begin
                @(negedge clk);
                chk(mem_valid && mem_addr == exp_a && mem_be == exp_be,
                    "R10 beat held", 64'(mem_addr), 64'(exp_a));
            end
            beat_done = 1'b1;
            @(negedge clk);
            beat_done = 1'b0;
            mem_rdata = {NB{8'h5A}};
        end
        chk(mem_valid == 1'b0, m ? "R1 beat count" : "R2 single beat", 64'(mem_valid), 64'd0);
        if (wr) begin
            chk(wr_ack && !rd_ack, "R6 write ack", 64'({wr_ack, rd_ack}), 64'b10);
        end else begin
            chk(rd_ack && !wr_ack, "R6 read ack", 64'({rd_ack, wr_ack}), 64'b10);
            chk(rd_data == exp_rd, "R5 assembled read", 64'(rd_data), 64'(exp_rd));
        end
        @(negedge clk);
        chk(!rd_ack && !wr_ack, "R6 ack single cycle", 64'({rd_ack, wr_ack}), 64'd0);
        if (!wr) chk(rd_data == exp_rd, "R6 rd_data held", 64'(rd_data), 64'(exp_rd));
        else     chk(rd_data == prev_rd, "R6 rd_data kept on write", 64'(rd_data), 64'(prev_rd));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_valid && mem_be == '0 && !rd_ack && !wr_ack && !err,
            "R9 reset state", 64'({mem_valid, mem_be, rd_ack, wr_ack, err}), 64'd0);
        for (int p = 0; p < 2; p++) begin
            for (int wr = 1; wr >= 0; wr--) begin
                for (int code = 0; code < 4; code++) begin
                    for (int m = 0; m < 2; m++) begin
                        logic [AW-1:0] a;
                        logic [HW-1:0] wd;
                        logic [NB-1:0] be;
                        a  = AW'(16'h0100 + p * 16'h0230 + code * 8);
                        wd = (p == 0) ? 32'hA1B2C3D4 : 32'h0F1E2D3C ^ HW'(code * 32'h01010101);
                        be = (p == 0) ? 4'b1111 : NB'(4'b1010 ^ NB'(code));
                        run(bit'(wr), code, bit'(m), a, wd, be);
                    end
                end
            end
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule